// File: doc/BRIEF.md
# UART Receive Timeout Timer

This block watches a UART receiver that has characters waiting in its receive FIFO. It tells the host when no new character has arrived and nobody has read the holding register for four whole character times. It counts 16x oversample ticks against a limit it works out from the current line settings. The settings are the data-bit count, whether a parity bit is present, and a stop length of one, one and a half or two bit times. When the count reaches that limit, the block raises a timeout flag.

The count starts again at the centre of every received stop bit and on every host read of the holding register. Either event also drops the flag. While the FIFO is empty the count is held at zero and the flag stays low, so timing begins fresh when the first character lands. The receiver supplies the oversample tick, the stop-centre strobe and the FIFO-empty flag. The host interface supplies the read strobe.

Top module: `rx_timeout_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rxto_flag` is 0.
- R2: One character time in oversample ticks is 16 × (1 start + data bits + parity bit) plus the stop length. Data bits are 5, 6, 7 or 8 for `word_len` codes 0, 1, 2, 3. The parity bit counts only when `parity_en` is 1. The stop length for `stop_len` code 0 is 16 ticks, for code 1 is 24 ticks, and for codes 2 and 3 is 32 ticks.
- R3: The timeout limit is four character times. `rxto_flag` stays 0 through limit−1 ticks after a restart and becomes 1 on the clock edge that takes the limit-th tick.
- R4: Clock cycles with `os_tick` low do not advance the count.
- R5: A cycle with `rhr_read` high restarts the count from zero and clears `rxto_flag` on the next edge. It wins over a tick in the same cycle.
- R6: A cycle with `stop_mid` high restarts the count and clears `rxto_flag`, in the same way as R5.
- R7: While `fifo_empty` is 1, the count is held at zero and `rxto_flag` is 0 from the next edge on. A full limit of ticks is counted again after the FIFO becomes non-empty.
- R8: Once set, `rxto_flag` stays 1, whatever further ticks arrive, until a read, a stop-bit centre, an empty FIFO or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| word_len | input | 2 | Data-bit count code (0..3 = 5..8 bits) |
| parity_en | input | 1 | 1 when frames carry a parity bit |
| stop_len | input | 2 | Stop length code: 0 = 1, 1 = 1.5, 2 or 3 = 2 bit times |
| fifo_empty | input | 1 | Receive FIFO holds no characters |
| stop_mid | input | 1 | Pulse at the centre of each received stop bit |
| rhr_read | input | 1 | Pulse when the host reads the holding register |
| rxto_flag | output | 1 | Receive timeout condition |

## Verification
The hardest case to reach is the exact tick on which the flag rises. It takes hundreds of ticks with no restart and a non-empty FIFO, and it must be hit for each line setting, including the half-bit stop. The bench sends ticks as single-cycle pulses. It counts them one by one, checks the flag just before and just after the computed limit, and repeats this for several settings. Restart and empty-FIFO cases are entered either part way through a count or while the flag is already set, so the clearing and the fresh count are both seen.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    // Stop-length selector codes
    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2,
        STOP_TWO_ALT  = 2'd3
    } stop_len_e;

    // Fewest data bits selected by word-length code 0
    localparam int MIN_DATA_BITS = 5;
    // Most data bits (code 3)
    localparam int MAX_DATA_BITS = 8;

endpackage

// File: rtl/rxto_frame_len.sv
module rxto_frame_len
    import rxto_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int CHARS = 4,
    parameter int LIM_W = 10
) (
    input  logic [1:0]       word_len,
    input  logic             parity_en,
    input  logic [1:0]       stop_len,
    output logic [LIM_W-1:0] limit
);
    localparam int HALF_OSR = OSR / 2;

    logic [LIM_W-1:0] whole_bits;
    logic [LIM_W-1:0] stop_ticks;
    logic [LIM_W-1:0] frame_ticks;

    always_comb begin
        // start bit + data bits + optional parity
        whole_bits = LIM_W'(1 + MIN_DATA_BITS) + LIM_W'(word_len) + LIM_W'(parity_en);
        unique case (stop_len_e'(stop_len))
            STOP_ONE:      stop_ticks = LIM_W'(OSR);
            STOP_ONE_HALF: stop_ticks = LIM_W'(OSR + HALF_OSR);
            default:       stop_ticks = LIM_W'(2 * OSR);
        endcase
        frame_ticks = whole_bits * LIM_W'(OSR) + stop_ticks;
        limit       = frame_ticks * LIM_W'(CHARS);
    end

endmodule

// File: rtl/rxto_counter.sv
module rxto_counter #(
    parameter int LIM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             fifo_empty,
    input  logic [LIM_W-1:0] limit,
    output logic             expired
);
    typedef struct packed {
        logic [LIM_W-1:0] count;
        logic             expired;
    } state_t;

    state_t state_d, state_q;
    logic [LIM_W-1:0] count_inc;

    always_comb begin
        state_d   = state_q;
        count_inc = state_q.count + LIM_W'(1);
        if (fifo_empty || restart) begin
            state_d.count   = '0;
            state_d.expired = 1'b0;
        end else if (tick && !state_q.expired) begin
            state_d.count = count_inc;
            if (count_inc >= limit) begin
                state_d.expired = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign expired = state_q.expired;

    // R7
    no_flag_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |=> (!state_q.expired && state_q.count == '0));

    // R5
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!state_q.expired && state_q.count == '0));

    // R4
    idle_holds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart && !fifo_empty) |=> $stable(state_q.count));

    // R3
    rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.expired) |-> $past(tick));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.expired && !restart && !fifo_empty) |=> state_q.expired);

endmodule

// File: rtl/rx_timeout_timer.sv
module rx_timeout_timer
    import rxto_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int CHARS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic [1:0] word_len,
    input  logic       parity_en,
    input  logic [1:0] stop_len,
    input  logic       fifo_empty,
    input  logic       stop_mid,
    input  logic       rhr_read,
    output logic       rxto_flag
);
    localparam int MAX_FRAME = OSR * (2 + MAX_DATA_BITS) + 2 * OSR;
    localparam int MAX_LIMIT = CHARS * MAX_FRAME;
    localparam int LIM_W     = $clog2(MAX_LIMIT + 1);

    logic [LIM_W-1:0] limit;
    logic             restart;

    assign restart = stop_mid | rhr_read;

    rxto_frame_len #(
        .OSR   (OSR),
        .CHARS (CHARS),
        .LIM_W (LIM_W)
    ) u_frame (
        .word_len  (word_len),
        .parity_en (parity_en),
        .stop_len  (stop_len),
        .limit     (limit)
    );

    rxto_counter #(
        .LIM_W (LIM_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .restart    (restart),
        .fifo_empty (fifo_empty),
        .limit      (limit),
        .expired    (rxto_flag)
    );

    // R6
    stop_centre_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mid |=> !rxto_flag);

endmodule

// File: tb/sim_rx_timeout_timer.sv
module sim_rx_timeout_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic       parity_en = 1'b0;
    logic [1:0] stop_len = 2'd0;
    logic       fifo_empty = 1'b0;
    logic       stop_mid = 1'b0;
    logic       rhr_read = 1'b0;
    logic       rxto_flag;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    rx_timeout_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_tick    (os_tick),
        .word_len   (word_len),
        .parity_en  (parity_en),
        .stop_len   (stop_len),
        .fifo_empty (fifo_empty),
        .stop_mid   (stop_mid),
        .rhr_read   (rhr_read),
        .rxto_flag  (rxto_flag)
    );

    function automatic int exp_limit(int wl, int par, int sl);
        int stop_t;
        stop_t = (sl == 0) ? 16 : (sl == 1) ? 24 : 32;
        return 4 * ((1 + 5 + wl + par) * 16 + stop_t);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rxto_flag=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic host_read();
        rhr_read = 1'b1;
        @(negedge clk);
        rhr_read = 1'b0;
    endtask

    task automatic stop_centre();
        stop_mid = 1'b1;
        @(negedge clk);
        stop_mid = 1'b0;
    endtask

    task automatic set_line(int wl, int par, int sl);
        word_len  = 2'(wl);
        parity_en = 1'(par);
        stop_len  = 2'(sl);
        host_read();
    endtask

    // R2, R3: limit edge for one line setting
    task automatic test_limit(string tag, int wl, int par, int sl);
        int lim;
        lim = exp_limit(wl, par, sl);
        set_line(wl, par, sl);
        ticks(lim - 1);
        chk({tag, " one tick short"}, rxto_flag, 1'b0);
        ticks(1);
        chk({tag, " at limit"}, rxto_flag, 1'b1);
    endtask

    task automatic test_reset();
        chk("R1 in reset", rxto_flag, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", rxto_flag, 1'b0);
    endtask

    task automatic test_sticky();
        test_limit("R3 8N1", 3, 0, 0);
        ticks(50);
        chk("R8 flag holds under ticks", rxto_flag, 1'b1);
        repeat (20) @(negedge clk);
        chk("R8 flag holds idle", rxto_flag, 1'b1);
    endtask

    task automatic test_read();
        int lim;
        lim = exp_limit(3, 0, 0);
        host_read();
        chk("R5 read clears flag", rxto_flag, 1'b0);
        ticks(lim - 1);
        chk("R5 full count after read", rxto_flag, 1'b0);
        ticks(1);
        chk("R5 expires after read", rxto_flag, 1'b1);
        // read in same cycle as tick wins
        ticks(lim - 2);
        os_tick  = 1'b1;
        rhr_read = 1'b1;
        @(negedge clk);
        os_tick  = 1'b0;
        rhr_read = 1'b0;
        chk("R5 read beats tick", rxto_flag, 1'b0);
    endtask

    task automatic test_stop();
        int lim;
        lim = exp_limit(3, 0, 0);
        host_read();
        ticks(300);
        stop_centre();
        ticks(lim - 1);
        chk("R6 stop centre restarts count", rxto_flag, 1'b0);
        ticks(1);
        chk("R6 expires after stop restart", rxto_flag, 1'b1);
        stop_centre();
        chk("R6 stop centre clears flag", rxto_flag, 1'b0);
    endtask

    task automatic test_idle();
        int lim;
        lim = exp_limit(1, 1, 1);
        set_line(1, 1, 1);
        ticks(lim - 1);
        repeat (60) @(negedge clk);
        chk("R4 idle clocks do not count", rxto_flag, 1'b0);
        ticks(1);
        chk("R4 tick completes count", rxto_flag, 1'b1);
    endtask

    task automatic test_empty();
        int lim;
        lim = exp_limit(0, 0, 0);
        set_line(0, 0, 0);
        ticks(lim);
        chk("R3 5N1 expiry", rxto_flag, 1'b1);
        fifo_empty = 1'b1;
        @(negedge clk);
        chk("R7 empty clears flag", rxto_flag, 1'b0);
        ticks(800);
        chk("R7 no flag while empty", rxto_flag, 1'b0);
        fifo_empty = 1'b0;
        ticks(lim - 1);
        chk("R7 fresh count after empty", rxto_flag, 1'b0);
        ticks(1);
        chk("R7 expiry after refill", rxto_flag, 1'b1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        test_reset();
        test_sticky();
        test_read();
        test_stop();
        test_limit("R2 5O1.5", 0, 1, 1);
        test_limit("R2 7E2", 2, 1, 2);
        test_limit("R2 6N2 code3", 1, 0, 3);
        test_idle();
        test_empty();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule